// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock for an I2C master from the core clock. A programmable divider sets the SCL period. The block pulls SCL low for half the period, then releases it for the other half. While SCL is released, the block watches the sensed line level. A target that holds SCL low (clock stretching) pauses the released half of the period until the line actually goes high.

Two one-cycle strobes tell the neighbouring shift logic when to act:
- The drive strobe marks when to present the next SDA bit, a programmable number of core clocks after SCL falls.
- The sample strobe marks when to capture SDA, a programmable number of core clocks after SCL is seen to rise.

A stretch monitor counts how many SCL periods the line has been held low after release. When that count reaches a programmed limit, it raises a sticky timeout flag. Software clears the flag with a write-one-to-clear pulse. Byte framing, start and stop conditions and the register interface are handled elsewhere.

Top module: `scl_timing_gen`

## Requirements
- R1: The effective divider is `div_val` with bit 0 forced to zero; any result below 2 is taken as 2. The half period `H` is the effective divider divided by 2, and the divider setting is registered before use.
- R2: While enabled and not stretched, `scl_drive_low` reads 1 for exactly `H` cycles and then 0 for exactly `H` cycles, repeating.
- R3: `drive_stb` is high for a single cycle, `F + 1` cycles after the first cycle in which `scl_drive_low` reads 1. `F` is the falling-edge delay taken from `dly_word[31:16]`.
- R4: `sample_stb` is high for a single cycle, `R + 1` cycles after the cycle in which `scl_in` is first seen high while SCL is released. `R` is the rising-edge delay taken from `dly_word[15:0]`.
- R5: A delay field larger than `H` is used as `H`.
- R6: While SCL is released but `scl_in` is sensed low, the released phase does not advance. The next low phase begins `H` cycles after `scl_in` goes high.
- R7: With `tmo_cycles = N` (nonzero), `tmo_flag` reads 1 exactly `N` × effective divider cycles after the first cycle of a stretch, and never before.
- R8: With `tmo_cycles = 0`, `tmo_flag` is never set, however long SCL is stretched.
- R9: `tmo_flag` stays at 1 until `tmo_clr` is high for a cycle, and reads 0 in the cycle after that.
- R10: One cycle after `en` is sampled low, `scl_drive_low` is 0. One cycle after `en` is sampled high from the disabled state, `scl_drive_low` is 1.
- R11: After synchronous reset, `scl_drive_low`, `drive_stb`, `sample_stb` and `tmo_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the SCL generator |
| div_val | input | 16 | Divider setting; bit 0 is ignored |
| dly_word | input | 32 | Falling-edge delay in bits 31:16, rising-edge delay in bits 15:0 |
| tmo_cycles | input | 16 | Stretch limit in SCL periods; 0 disables it |
| tmo_clr | input | 1 | Write-one-to-clear for the timeout flag |
| scl_in | input | 1 | Sensed SCL level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| drive_stb | output | 1 | Strobe to present the next SDA bit |
| sample_stb | output | 1 | Strobe to capture SDA |
| tmo_flag | output | 1 | Sticky stretch-timeout flag |

## Verification
The bench builds the block with its default 16-bit divider, delay and timeout widths. Divider values stay small (0 to 20), so each SCL phase spans only a handful of cycles. This puts the odd divider, the sub-minimum divider and delays that are clamped to the half period within a few dozen cycles each. A small timeout limit of 3 periods makes the exact cycle of flag assertion, its stickiness and its clearing observable inside one stretched phase.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
  localparam int unsigned CW = 16;

  typedef struct packed {
    logic [CW-1:0] period;
    logic [CW-1:0] half;
    logic [CW-1:0] fall_dly;
    logic [CW-1:0] rise_dly;
  } scl_cfg_t;
endpackage

// File: rtl/scl_cfg_norm.sv
module scl_cfg_norm
  import scl_timing_pkg::*;
#(
  parameter int unsigned W = CW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   div_val,
  input  logic [2*W-1:0] dly_word,
  output scl_cfg_t       cfg
);
  localparam logic [W-1:0] MIN_PER = W'(2);

  logic [W-1:0] per, hf, f_raw, r_raw;

  always_comb begin
    per = {div_val[W-1:1], 1'b0};
    if (per < MIN_PER) per = MIN_PER;
    hf    = per >> 1;
    f_raw = dly_word[2*W-1:W];
    r_raw = dly_word[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.period   <= MIN_PER;
      cfg.half     <= W'(1);
      cfg.fall_dly <= '0;
      cfg.rise_dly <= '0;
    end else begin
      cfg.period   <= per;
      cfg.half     <= hf;
      cfg.fall_dly <= (f_raw > hf) ? hf : f_raw;
      cfg.rise_dly <= (r_raw > hf) ? hf : r_raw;
    end
  end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] half,
  input  logic         scl_in,
  output logic         scl_low,
  output logic         running
);
  logic [W-1:0] cnt;
  logic         last;

  assign last = (cnt == half - W'(1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      running <= 1'b0;
      scl_low <= 1'b0;
      cnt     <= '0;
    end else if (!running) begin
      running <= 1'b1;
      scl_low <= 1'b1;
      cnt     <= '0;
    end else if (scl_low) begin
      if (last) begin
        scl_low <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + W'(1);
      end
    end else if (scl_in) begin
      if (last) begin
        scl_low <= 1'b1;
        cnt     <= '0;
      end else begin
        cnt <= cnt + W'(1);
      end
    end
  end
endmodule

// File: rtl/scl_edge_strobe.sv
module scl_edge_strobe #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic         evt,
  input  logic [W-1:0] dly,
  output logic         stb
);
  logic         armed;
  logic [W-1:0] elap, cur;
  logic         hit;

  always_comb begin
    cur = evt ? '0 : elap + W'(1);
    hit = (evt || armed) && (cur == dly);
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      armed <= 1'b0;
      elap  <= '0;
      stb   <= 1'b0;
    end else begin
      stb  <= hit;
      elap <= cur;
      if (hit)      armed <= 1'b0;
      else if (evt) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/scl_stretch_mon.sv
module scl_stretch_mon #(
  parameter int unsigned W  = 16,
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          scl_low,
  input  logic          scl_in,
  input  logic [W-1:0]  period,
  input  logic [TW-1:0] limit,
  input  logic          clr,
  output logic          flag
);
  logic [W-1:0]  sub;
  logic [TW-1:0] per;
  logic          stretched, wrap, set;

  always_comb begin
    stretched = active && !scl_low && !scl_in;
    wrap      = (sub == period - W'(1));
    set       = stretched && wrap && (limit != '0) &&
                ({1'b0, per} + (TW+1)'(1) == {1'b0, limit});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub  <= '0;
      per  <= '0;
      flag <= 1'b0;
    end else begin
      if (!stretched) begin
        sub <= '0;
        per <= '0;
      end else if (wrap) begin
        sub <= '0;
        if (per != '1) per <= per + TW'(1);
      end else begin
        sub <= sub + W'(1);
      end
      if (set)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int unsigned TMO_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CW-1:0]     div_val,
  input  logic [2*CW-1:0]   dly_word,
  input  logic [TMO_W-1:0]  tmo_cycles,
  input  logic              tmo_clr,
  input  logic              scl_in,
  output logic              scl_drive_low,
  output logic              drive_stb,
  output logic              sample_stb,
  output logic              tmo_flag
);
  localparam int unsigned N_EDGE = 2;

  scl_cfg_t    cfg;
  logic        running, scl_low, prev_low, prev_in;
  logic [N_EDGE-1:0] evt, stb;
  logic [CW-1:0]     dly [N_EDGE];

  scl_cfg_norm #(.W(CW)) u_cfg (
    .clk(clk), .rst(rst), .div_val(div_val), .dly_word(dly_word), .cfg(cfg)
  );

  scl_phase_gen #(.W(CW)) u_phase (
    .clk(clk), .rst(rst), .en(en), .half(cfg.half), .scl_in(scl_in),
    .scl_low(scl_low), .running(running)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_low <= 1'b0;
      prev_in  <= 1'b1;
    end else begin
      prev_low <= scl_low;
      prev_in  <= scl_in;
    end
  end

  assign evt[0] = scl_low && !prev_low;
  assign evt[1] = running && !scl_low && scl_in && !prev_in;
  assign dly[0] = cfg.fall_dly;
  assign dly[1] = cfg.rise_dly;

  for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
    scl_edge_strobe #(.W(CW)) u_stb (
      .clk(clk), .rst(rst), .active(running), .evt(evt[g]),
      .dly(dly[g]), .stb(stb[g])
    );
  end

  scl_stretch_mon #(.W(CW), .TW(TMO_W)) u_mon (
    .clk(clk), .rst(rst), .active(running), .scl_low(scl_low),
    .scl_in(scl_in), .period(cfg.period), .limit(tmo_cycles),
    .clr(tmo_clr), .flag(tmo_flag)
  );

  assign scl_drive_low = scl_low;
  assign drive_stb     = stb[0];
  assign sample_stb    = stb[1];
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk #(
  parameter int unsigned TMO_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [TMO_W-1:0] tmo_cycles,
  input logic             tmo_clr,
  input logic             scl_in,
  input logic             scl_drive_low,
  input logic             drive_stb,
  input logic             sample_stb,
  input logic             tmo_flag
);
  p_drive_single_r3: assert property (@(posedge clk) disable iff (rst)
    drive_stb |=> !drive_stb);

  p_sample_single_r4: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);

  p_stretch_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !scl_drive_low && !scl_in) |=> !scl_drive_low);

  p_flag_while_released_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_flag) |-> !scl_drive_low);

  p_no_flag_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    (tmo_cycles == '0 && !tmo_flag) |=> !tmo_flag);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (tmo_flag && !tmo_clr) |=> tmo_flag);

  p_release_off_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !scl_drive_low);
endmodule

bind scl_timing_gen scl_timing_gen_chk #(.TMO_W(TMO_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .tmo_cycles(tmo_cycles),
  .tmo_clr(tmo_clr), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
  .drive_stb(drive_stb), .sample_stb(sample_stb), .tmo_flag(tmo_flag)
);

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [15:0] div_val = 16'd8;
  logic [31:0] dly_word = '0;
  logic [15:0] tmo_cycles = '0;
  logic        tmo_clr = 1'b0;
  logic        stretch = 1'b0;
  logic        scl_in;
  logic        scl_drive_low, drive_stb, sample_stb, tmo_flag;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  assign scl_in = ~scl_drive_low & ~stretch;

  scl_timing_gen dut_i (
    .clk(clk), .rst(rst), .en(en), .div_val(div_val), .dly_word(dly_word),
    .tmo_cycles(tmo_cycles), .tmo_clr(tmo_clr), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .drive_stb(drive_stb),
    .sample_stb(sample_stb), .tmo_flag(tmo_flag)
  );

  // {div, delay word, half, fall, rise}
  localparam logic [71:0] VEC [0:5] = '{
    {16'd8,  32'h0001_0002, 8'd4,  8'd1,  8'd2},
    {16'd9,  32'h0000_0000, 8'd4,  8'd0,  8'd0},
    {16'd12, 32'h0009_0003, 8'd6,  8'd6,  8'd3},
    {16'd0,  32'h0005_0005, 8'd1,  8'd1,  8'd1},
    {16'd1,  32'h0000_0000, 8'd1,  8'd0,  8'd0},
    {16'd20, 32'h000A_0014, 8'd10, 8'd10, 8'd10}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_low(input logic lvl);
    while (scl_drive_low !== lvl) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] d, input logic [31:0] w);
    en = 1'b0;
    div_val = d;
    dly_word = w;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(scl_drive_low == 0, "R11 scl", scl_drive_low, 0);
    chk(drive_stb == 0 && sample_stb == 0, "R11 strobes", drive_stb | sample_stb, 0);
    chk(tmo_flag == 0, "R11 flag", tmo_flag, 0);

    for (int v = 0; v < 6; v++) begin
      int h, f, r, kd, kr, ks, kl;
      h = int'(VEC[v][23:16]);
      f = int'(VEC[v][15:8]);
      r = int'(VEC[v][7:0]);
      setup(VEC[v][71:56], VEC[v][55:24]);
      en = 1'b1;
      @(negedge clk);
      if (v == 0) chk(scl_drive_low == 1, "R10 start", scl_drive_low, 1);
      wait_low(1'b1);
      kd = -1; kr = -1; ks = -1; kl = -1;
      for (int k = 0; k < 3*h + 4; k++) begin
        if (k > 0) @(negedge clk);
        if (drive_stb && kd < 0) kd = k;
        if (!scl_drive_low && kr < 0 && k > 0) kr = k;
        if (sample_stb && ks < 0 && k >= h) ks = k;
        if (scl_drive_low && kr >= 0 && kl < 0) kl = k;
      end
      chk(kr == h, "R1 low phase", kr, h);
      chk(kl == 2*h, "R2 period", kl, 2*h);
      chk(kd == f + 1, "R3 drive offset (R5 clamp)", kd, f + 1);
      chk(ks == h + r + 1, "R4 sample offset (R5 clamp)", ks, h + r + 1);
    end

    // R10 disable releases SCL
    en = 1'b0;
    @(negedge clk);
    chk(scl_drive_low == 0, "R10 release", scl_drive_low, 0);
    @(negedge clk);
    chk(drive_stb == 0 && sample_stb == 0, "R10 idle strobes", drive_stb | sample_stb, 0);

    // Stretch with timeout of 3 periods, divider 8
    setup(16'd8, 32'h0001_0002);
    tmo_cycles = 16'd3;
    en = 1'b1;
    wait_low(1'b1);
    stretch = 1'b1;
    wait_low(1'b0);
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 23) chk(tmo_flag == 0, "R7 early", tmo_flag, 0);
      if (k == 24) chk(tmo_flag == 1, "R7 set", tmo_flag, 1);
      if (k == 29) chk(scl_drive_low == 0, "R6 paused", scl_drive_low, 0);
      if (k == 30) stretch = 1'b0;
      if (k == 33) begin
        chk(sample_stb == 1, "R4 after stretch", sample_stb, 1);
        chk(scl_drive_low == 0, "R6 high length", scl_drive_low, 0);
      end
      if (k == 34) chk(scl_drive_low == 1, "R6 resume", scl_drive_low, 1);
      if (k == 40) chk(tmo_flag == 1, "R9 sticky", tmo_flag, 1);
    end
    tmo_clr = 1'b1;
    @(negedge clk);
    tmo_clr = 1'b0;
    chk(tmo_flag == 0, "R9 cleared", tmo_flag, 0);

    // R8 timeout disabled
    tmo_cycles = 16'd0;
    wait_low(1'b1);
    stretch = 1'b1;
    wait_low(1'b0);
    repeat (48) @(negedge clk);
    chk(tmo_flag == 0, "R8 disabled", tmo_flag, 0);
    chk(scl_drive_low == 0, "R6 long stretch", scl_drive_low, 0);
    stretch = 1'b0;
    repeat (4) @(negedge clk);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule